// File: doc/BRIEF.md
# I2C Controller Control and Keyed Soft-Reset Register Front End

This block is the register front end of an I2C master/slave controller. It decodes a simple 32-bit write/read bus and holds two registers. The control register sets up the bit-level engine: general-call enable, acknowledge level, repeated start, transfer direction, master select, transmit-queue reset and core enable. The soft-reset register takes a 4-bit key. Writing the right key clears only the interrupt register group. Any other key gets an error response.

Starting a transfer is tied to the state of the transmit queue. A START is launched when master select goes from 0 to 1 and the queue already holds the target address byte. A repeated start is launched when the repeated-start bit goes from 0 to 1 and the queue is still empty, because the address byte is pushed afterwards. Either request made against the wrong queue state is dropped and a launch-error flag is raised. The engine uses the enable bit as its run gate. While enable is 0, fields can still be written, but no launch happens. Every access gets a registered response one cycle after its strobe.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After reset, every output is 0 and a read of the control register returns 0.
- R2: The control register sits at byte offset 0x100. Write-data bits map as: bit 0 enable, bit 1 transmit-queue reset, bit 2 master select, bit 3 transmit direction, bit 4 repeated start, bit 5 acknowledge level, bit 6 general-call enable. Each field drives its own output. Bits 31..7 are ignored on write and read back as 0.
- R3: A write to byte offset 0x040 with bits 3..0 equal to 0xA gives a one-cycle `irq_regs_rst` pulse in the response cycle and a response without error. Bits 31..4 are ignored, and the control register keeps its value.
- R4: A write to 0x040 with any other key raises `bus_err` in the response cycle and gives no `irq_regs_rst` pulse.
- R5: A read of 0x040 returns 0.
- R6: A control write with enable 1 that takes master select from 0 to 1 while `txq_empty` is 0 gives a one-cycle `start_pulse` in the response cycle. The same write also sets all the other fields.
- R7: A control write with enable 1 that takes master select from 0 to 1 while `txq_empty` is 1 gives no `start_pulse` and sets `launch_err`.
- R8: A control write with enable 1 that takes repeated start from 0 to 1 gives a one-cycle `rstart_pulse` if `txq_empty` is 1. If `txq_empty` is 0, it gives no pulse and sets `launch_err`.
- R9: A control write with enable 0 stores its fields but gives no start, no repeated start and no `launch_err`.
- R10: `launch_err` holds until the next control write. It is then cleared, unless that write is itself dropped. `launch_err` never coincides with a launch pulse.
- R11: Every write or read strobe gets a `bus_ack` exactly one cycle later. `bus_err` is set only for a rejected key.
- R12: `ctl_txq_rst` stays 1 for as long as control bit 1 holds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| txq_empty | input | 1 | Transmit queue holds no bytes |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access response, one cycle after the strobe |
| bus_err | output | 1 | Error response (rejected key) |
| ctl_en | output | 1 | Core enable |
| ctl_txq_rst | output | 1 | Transmit-queue reset level |
| ctl_master | output | 1 | Master select |
| ctl_dir_tx | output | 1 | Transmit direction |
| ctl_rstart | output | 1 | Repeated-start bit |
| ctl_txack | output | 1 | Acknowledge level driven when receiving |
| ctl_gcall | output | 1 | General-call enable |
| start_pulse | output | 1 | One-cycle START launch |
| rstart_pulse | output | 1 | One-cycle repeated-start launch |
| launch_err | output | 1 | Last control write had its launch dropped |
| irq_regs_rst | output | 1 | One-cycle reset of the interrupt register group |

## Verification
The assertions assume a well-behaved bus master. It raises at most one strobe per cycle, and it does not strobe during the two cycles after reset release. They also assume `txq_empty` does not change in the cycle it is sampled by a control write. The bench drives every strobe as a single-cycle pulse spaced by idle cycles. It changes `txq_empty` only between accesses and waits well past the reset synchronizer before its first access.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int DATA_W   = 32;
  localparam int CTRL_W   = 7;
  localparam int KEY_W    = 4;
  localparam logic [KEY_W-1:0] KEY_VAL = 4'hA;
  localparam logic [11:0] OFF_SRST = 12'h040;
  localparam logic [11:0] OFF_CTRL = 12'h100;

  // packed MSB first: gcall is bit 6, en is bit 0
  typedef struct packed {
    logic gcall;
    logic txack;
    logic rstart;
    logic dir_tx;
    logic master;
    logic txq_rst;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/i2c_addr_dec.sv
module i2c_addr_dec
  import i2c_ctl_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_ctrl,
  output logic              wr_srst,
  output logic              rd_ctrl,
  output logic              any_acc
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_SRST = ADDR_W'(OFF_SRST);

  logic hit_ctrl, hit_srst;

  always_comb begin
    hit_ctrl = (bus_addr == A_CTRL);
    hit_srst = (bus_addr == A_SRST);
    wr_ctrl  = bus_wr & hit_ctrl;
    wr_srst  = bus_wr & hit_srst;
    rd_ctrl  = bus_rd & hit_ctrl;
    any_acc  = bus_wr | bus_rd;
  end
endmodule

// File: rtl/i2c_ctrl_reg.sv
module i2c_ctrl_reg
  import i2c_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ctrl,
  input  ctrl_t wr_val,
  input  logic  txq_empty,
  output ctrl_t ctrl_q,
  output logic  start_pulse,
  output logic  rstart_pulse,
  output logic  launch_err
);
  ctrl_t ctrl_d;
  logic  start_d, rstart_d, err_d;
  logic  ms_rise, rs_rise, blocked;

  always_comb begin
    ctrl_d   = ctrl_q;
    start_d  = 1'b0;
    rstart_d = 1'b0;
    err_d    = launch_err;
    ms_rise  = 1'b0;
    rs_rise  = 1'b0;
    blocked  = 1'b0;
    if (wr_ctrl) begin
      ctrl_d   = wr_val;
      ms_rise  = wr_val.master & ~ctrl_q.master;
      rs_rise  = wr_val.rstart & ~ctrl_q.rstart;
      // a launch against the wrong queue state drops every launch of this write
      blocked  = wr_val.en & ((ms_rise & txq_empty) | (rs_rise & ~txq_empty));
      start_d  = wr_val.en & ms_rise & ~txq_empty & ~blocked;
      rstart_d = wr_val.en & rs_rise &  txq_empty & ~blocked;
      err_d    = blocked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      start_pulse  <= 1'b0;
      rstart_pulse <= 1'b0;
      launch_err   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      start_pulse  <= start_d;
      rstart_pulse <= rstart_d;
      launch_err   <= err_d;
    end
  end
endmodule

// File: rtl/i2c_srst_key.sv
module i2c_srst_key
  import i2c_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_srst,
  input  logic [KEY_W-1:0] key,
  output logic             key_bad,
  output logic             irq_regs_rst
);
  logic irq_d;

  always_comb begin
    key_bad = (key != KEY_VAL);
    irq_d   = wr_srst & ~key_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_regs_rst <= 1'b0;
    else        irq_regs_rst <= irq_d;
  end
endmodule

// File: rtl/i2c_bus_resp.sv
module i2c_bus_resp
  import i2c_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_acc,
  input  logic              wr_srst,
  input  logic              key_bad,
  input  logic              rd_ctrl,
  input  ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              bus_err
);
  logic [DATA_W-1:0] rdata_d;
  logic              ack_d, err_d;

  always_comb begin
    ack_d   = any_acc;
    err_d   = wr_srst & key_bad;
    rdata_d = rd_ctrl ? DATA_W'(ctrl_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= ack_d;
      bus_err <= err_d;
      if (any_acc) bus_rdata <= rdata_d;
      else         bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_ctl_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              txq_empty,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  output logic              bus_err,
  output logic              ctl_en,
  output logic              ctl_txq_rst,
  output logic              ctl_master,
  output logic              ctl_dir_tx,
  output logic              ctl_rstart,
  output logic              ctl_txack,
  output logic              ctl_gcall,
  output logic              start_pulse,
  output logic              rstart_pulse,
  output logic              launch_err,
  output logic              irq_regs_rst
);
  logic  rst_sn;
  logic  wr_ctrl, wr_srst, rd_ctrl, any_acc, key_bad;
  ctrl_t ctrl_q;
  ctrl_t wr_val;

  assign wr_val = ctrl_t'(bus_wdata[CTRL_W-1:0]);

  i2c_rst_sync u_rst (
    .clk    (clk),
    .rst_an (rst_n),
    .rst_sn (rst_sn)
  );

  i2c_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .wr_ctrl  (wr_ctrl),
    .wr_srst  (wr_srst),
    .rd_ctrl  (rd_ctrl),
    .any_acc  (any_acc)
  );

  i2c_ctrl_reg u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sn),
    .wr_ctrl      (wr_ctrl),
    .wr_val       (wr_val),
    .txq_empty    (txq_empty),
    .ctrl_q       (ctrl_q),
    .start_pulse  (start_pulse),
    .rstart_pulse (rstart_pulse),
    .launch_err   (launch_err)
  );

  i2c_srst_key u_key (
    .clk          (clk),
    .rst_n        (rst_sn),
    .wr_srst      (wr_srst),
    .key          (bus_wdata[KEY_W-1:0]),
    .key_bad      (key_bad),
    .irq_regs_rst (irq_regs_rst)
  );

  i2c_bus_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_sn),
    .any_acc   (any_acc),
    .wr_srst   (wr_srst),
    .key_bad   (key_bad),
    .rd_ctrl   (rd_ctrl),
    .ctrl_q    (ctrl_q),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err)
  );

  assign ctl_en      = ctrl_q.en;
  assign ctl_txq_rst = ctrl_q.txq_rst;
  assign ctl_master  = ctrl_q.master;
  assign ctl_dir_tx  = ctrl_q.dir_tx;
  assign ctl_rstart  = ctrl_q.rstart;
  assign ctl_txack   = ctrl_q.txack;
  assign ctl_gcall   = ctrl_q.gcall;
endmodule

// File: rtl/i2c_ctl_regs_chk.sv
module i2c_ctl_regs_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              txq_empty,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              ctl_en,
  input logic              ctl_master,
  input logic              ctl_rstart,
  input logic              start_pulse,
  input logic              rstart_pulse,
  input logic              launch_err,
  input logic              irq_regs_rst
);
  localparam logic [ADDR_W-1:0] A_SRST = ADDR_W'(12'h040);

  // R3
  a_r3_irq_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    irq_regs_rst |-> $past(bus_wr && bus_addr == A_SRST && bus_wdata[3:0] == 4'hA));
  a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_regs_rst |=> !irq_regs_rst);
  // R4
  a_r4_err_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !irq_regs_rst);
  a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_wr && bus_addr == A_SRST && bus_wdata[3:0] != 4'hA));
  // R6
  a_r6_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> ($past(!txq_empty) && ctl_en && ctl_master));
  a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  // R8
  a_r8_rstart_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_pulse |-> ($past(txq_empty) && ctl_en && ctl_rstart));
  // R9
  a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> (!start_pulse && !rstart_pulse && !launch_err));
  // R10
  a_r10_err_vs_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, rstart_pulse, launch_err}));
  // R11
  a_r11_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |=> bus_ack);
  a_r11_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_wr || bus_rd));
endmodule

bind i2c_ctl_regs i2c_ctl_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .txq_empty    (txq_empty),
  .bus_ack      (bus_ack),
  .bus_err      (bus_err),
  .ctl_en       (ctl_en),
  .ctl_master   (ctl_master),
  .ctl_rstart   (ctl_rstart),
  .start_pulse  (start_pulse),
  .rstart_pulse (rstart_pulse),
  .launch_err   (launch_err),
  .irq_regs_rst (irq_regs_rst)
);

// File: tb/i2c_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module i2c_ctl_regs_tb_top;
  localparam int ADDR_W = 9;
  localparam logic [ADDR_W-1:0] A_CTRL = 9'h100;
  localparam logic [ADDR_W-1:0] A_SRST = 9'h040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic txq_empty = 1'b1;
  logic [31:0] bus_rdata;
  logic bus_ack, bus_err;
  logic ctl_en, ctl_txq_rst, ctl_master, ctl_dir_tx, ctl_rstart, ctl_txack, ctl_gcall;
  logic start_pulse, rstart_pulse, launch_err, irq_regs_rst;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // values captured in the response cycle and in the cycle after it
  logic [31:0] r_rdata;
  logic r_ack, r_err, r_st, r_rs, r_irq, r_lerr;
  logic n_st, n_rs, n_irq;

  always #2.5 clk = ~clk;

  i2c_ctl_regs #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .txq_empty(txq_empty),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
    .ctl_en(ctl_en), .ctl_txq_rst(ctl_txq_rst), .ctl_master(ctl_master),
    .ctl_dir_tx(ctl_dir_tx), .ctl_rstart(ctl_rstart), .ctl_txack(ctl_txack),
    .ctl_gcall(ctl_gcall), .start_pulse(start_pulse), .rstart_pulse(rstart_pulse),
    .launch_err(launch_err), .irq_regs_rst(irq_regs_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = ~wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    r_rdata = bus_rdata; r_ack = bus_ack; r_err = bus_err;
    r_st = start_pulse; r_rs = rstart_pulse; r_irq = irq_regs_rst; r_lerr = launch_err;
    @(negedge clk);
    n_st = start_pulse; n_rs = rstart_pulse; n_irq = irq_regs_rst;
  endtask

  task automatic t_reset();
    chk("R1 outputs", {ctl_en, ctl_txq_rst, ctl_master, ctl_dir_tx, ctl_rstart, ctl_txack,
         ctl_gcall, start_pulse, rstart_pulse, launch_err, irq_regs_rst, bus_ack, bus_err}, 0);
    access(1'b0, A_CTRL, 0);
    chk("R1 ctrl read", r_rdata, 0);
    chk("R11 read ack", r_ack, 1);
  endtask

  task automatic t_fields();
    // gcall, txack, dir, txq reset set; enable off; reserved bits all 1
    access(1'b1, A_CTRL, 32'hFFFF_FF6A);
    chk("R11 write ack", {r_ack, r_err}, 2'b10);
    chk("R2 field outputs", {ctl_gcall, ctl_txack, ctl_rstart, ctl_dir_tx, ctl_master,
         ctl_txq_rst, ctl_en}, 7'b1101010);
    chk("R12 txq reset held", ctl_txq_rst, 1);
    access(1'b0, A_CTRL, 0);
    chk("R2 readback reserved zero", r_rdata, 32'h6A);
    chk("R12 txq reset still held", ctl_txq_rst, 1);
    access(1'b1, A_CTRL, 0);
    chk("R12 txq reset released", ctl_txq_rst, 0);
  endtask

  task automatic t_disabled();
    txq_empty = 1'b0;
    access(1'b1, A_CTRL, 32'h14);
    chk("R9 no launch when off", {r_st, r_rs, r_lerr}, 0);
    access(1'b0, A_CTRL, 0);
    chk("R9 fields stored", r_rdata, 32'h14);
    access(1'b1, A_CTRL, 0);
  endtask

  task automatic t_start_ok();
    txq_empty = 1'b0;
    access(1'b1, A_CTRL, 32'h0D);
    chk("R6 start pulse", {r_st, r_rs, r_lerr}, 3'b100);
    chk("R6 start one cycle", n_st, 0);
    chk("R6 same write sets dir", {ctl_dir_tx, ctl_master, ctl_en}, 3'b111);
    access(1'b1, A_CTRL, 0);
  endtask

  task automatic t_start_empty();
    txq_empty = 1'b1;
    access(1'b1, A_CTRL, 32'h05);
    chk("R7 start dropped", {r_st, r_lerr}, 2'b01);
    chk("R10 flag held", launch_err, 1);
    access(1'b1, A_CTRL, 32'h01);
    chk("R10 flag cleared", r_lerr, 0);
    access(1'b1, A_CTRL, 0);
  endtask

  task automatic t_rstart();
    txq_empty = 1'b0;
    access(1'b1, A_CTRL, 32'h05);
    chk("R6 start before rstart", r_st, 1);
    txq_empty = 1'b1;
    access(1'b1, A_CTRL, 32'h15);
    chk("R8 rstart on empty", {r_st, r_rs, r_lerr}, 3'b010);
    chk("R8 rstart one cycle", n_rs, 0);
    access(1'b1, A_CTRL, 32'h05);
    txq_empty = 1'b0;
    access(1'b1, A_CTRL, 32'h15);
    chk("R8 rstart dropped on data", {r_rs, r_lerr}, 2'b01);
    access(1'b1, A_CTRL, 0);
  endtask

  task automatic t_softrst();
    access(1'b1, A_CTRL, 32'h68);
    access(1'b1, A_SRST, 32'hFFFF_FFFA);
    chk("R3 irq pulse no err", {r_irq, r_err, r_ack}, 3'b101);
    chk("R3 irq one cycle", n_irq, 0);
    access(1'b0, A_CTRL, 0);
    chk("R3 ctrl untouched", r_rdata, 32'h68);
    access(1'b0, A_SRST, 0);
    chk("R5 srst reads zero", r_rdata, 0);
    access(1'b1, A_SRST, 32'h0000_0005);
    chk("R4 bad key err", {r_err, r_irq, r_ack}, 3'b101);
    access(1'b1, A_SRST, 32'h0000_000B);
    chk("R4 near key err", {r_err, r_irq}, 2'b10);
    chk("R11 err one cycle", bus_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_fields();
    t_disabled();
    t_start_ok();
    t_start_empty();
    t_rstart();
    t_softrst();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule